// File: doc/BRIEF.md
# SMBus Alert Generation and Response Unit

This unit watches a vector of fault flags, each gated by its own enable bit. It drives an active-low open-drain alert line whenever a newly enabled fault appears. A fault that stays set, or that keeps being reported while its flag is still set, does not raise a second alert. A new alert needs either a different enabled bit to rise or the same bit to clear and then set again.

A surrounding bus engine decodes START, STOP and address bytes and passes the unit single-cycle events:

- the Alert Response Address (0001100, read) matched;
- the device's own slave address matched;
- the SCL falling edge, when the next data bit goes out;
- the SCL rising edge, when SDA is sampled.

The unit acknowledges the alert response read only while it holds the alert line low. It then shifts out its own 7-bit address followed by a 1, most significant bit first. When that byte completes, it lets the alert line go. If another responder wins arbitration, it stops driving at once and keeps alerting. Plain addressing by the device's own address also clears the alert.

Top module: `smb_alert_unit`

## Requirements
- R1: While reset is applied and after it is released, alert_n_o is 1, ack_req_o is 0 and sda_low_o is 0.
- R2: When any bit of (fault_i AND alert_en_i) goes from 0 to 1, alert_n_o reads 0 one clock after the edge that samples the change.
- R3: A fault bit whose enable bit is 0 never pulls alert_n_o low.
- R4: After the alert is released, a fault bit that remains set produces no new alert. The same bit cleared and set again does produce one.
- R5: After a release, a different enabled fault bit becoming set produces a new alert.
- R6: An ara_hit_i pulse while alert_n_o is 0 makes ack_req_o read 1 from the next clock until the first bit_load_i pulse.
- R7: An ara_hit_i pulse while alert_n_o is 1 is ignored. ack_req_o stays 0 and sda_low_o stays 0 through the following bit_load_i pulses.
- R8: The response byte is {dev_addr_i[6:0], 1'b1}, sent MSB first. For each bit, sda_low_o equals the inverse of that bit from the clock after its bit_load_i pulse (after the ACK slot for the first bit) until the next bit_load_i.
- R9: The bit_sample_i pulse of the eighth bit, with no arbitration loss, releases the alert. alert_n_o reads 1 one clock later.
- R10: If a bit sent as 1 samples sda_i as 0, sda_low_o is 0 from the next clock for the rest of the byte, and alert_n_o stays 0.
- R11: A dev_hit_i pulse releases the alert. alert_n_o reads 1 one clock later.
- R12: If a release and a new enabled fault rise fall in the same clock, the alert stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fault_i | input | NFLT | Fault flag vector |
| alert_en_i | input | NFLT | Per-fault alert enable mask |
| dev_addr_i | input | ADDR_W | Device's own slave address |
| ara_hit_i | input | 1 | Pulse: Alert Response Address read matched |
| dev_hit_i | input | 1 | Pulse: device addressed by its own address |
| bit_load_i | input | 1 | Pulse: SCL low phase, present the next bit |
| bit_sample_i | input | 1 | Pulse: SCL high phase, sample SDA |
| sda_i | input | 1 | Sampled SDA line level |
| alert_n_o | output | 1 | Active-low alert (0 = pull line low) |
| ack_req_o | output | 1 | Request to acknowledge the current address byte |
| sda_low_o | output | 1 | 1 = pull SDA low for the response byte |

## Verification
Every result of this unit is due exactly one clock after the edge that samples the causing event:

- the alert assertion after a fault edge;
- the alert release after a device hit or the eighth sampled bit;
- ack_req_o after the response match;
- the new SDA level after a load pulse or a lost bit.

The bench changes inputs only at falling clock edges and reads outputs at the next falling edge, which is one full rising edge later. Each check therefore sees the value registered by that single edge. Sweeps cover every fault bit with its enable on and off, eight device addresses through the whole response byte, and arbitration loss at the first released bit of two address patterns.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_ACK   = 2'd1,
    RSP_SHIFT = 2'd2
  } rsp_state_e;
endpackage

// File: rtl/smb_alert_rearm.sv
module smb_alert_rearm #(
  parameter int NFLT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLT-1:0] fault_i,
  input  logic [NFLT-1:0] en_i,
  output logic            rise_any_o
);
  logic [NFLT-1:0] masked;
  logic [NFLT-1:0] prev_q;
  logic [NFLT-1:0] rise;

  for (genvar g = 0; g < NFLT; g++) begin : g_bit
    assign masked[g] = fault_i[g] & en_i[g];
    assign rise[g]   = masked[g] & ~prev_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= masked[g];
    end
  end

  assign rise_any_o = |rise;

  // R3: a bit with its enable low can never be the cause of a rise
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_i & en_i) == '0) |-> !rise_any_o);
endmodule

// File: rtl/smb_alert_latch.sv
module smb_alert_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_any_i,
  input  logic dev_hit_i,
  input  logic resp_done_i,
  output logic alert_q_o
);
  logic alert_q, alert_d, release_evt;

  assign release_evt = dev_hit_i | resp_done_i;

  always_comb begin
    alert_d = alert_q;
    if (rise_any_i)       alert_d = 1'b1;
    else if (release_evt) alert_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_q <= 1'b0;
    else        alert_q <= alert_d;
  end

  assign alert_q_o = alert_q;

  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rise_any_i |=> alert_q);
  a_r11_dev_release: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_hit_i && !rise_any_i) |=> !alert_q);
  a_r9_resp_release: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done_i && !rise_any_i) |=> !alert_q);
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && rise_any_i) |=> alert_q);
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder
  import smb_alert_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alert_active_i,
  input  logic              ara_hit_i,
  input  logic              bit_load_i,
  input  logic              bit_sample_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              ack_req_o,
  output logic              sda_low_o,
  output logic              done_o
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  rsp_state_e        state_q, state_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              lost;

  assign lost = shreg_q[BYTE_W-1] & ~sda_i;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    done_o  = 1'b0;
    case (state_q)
      RSP_IDLE: if (ara_hit_i && alert_active_i) state_d = RSP_ACK;
      RSP_ACK: if (bit_load_i) begin
        state_d = RSP_SHIFT;
        shreg_d = {dev_addr_i, 1'b1};
        cnt_d   = '0;
      end
      RSP_SHIFT: begin
        if (bit_sample_i) begin
          if (lost) begin
            state_d = RSP_IDLE;
          end else if (cnt_q == LAST) begin
            state_d = RSP_IDLE;
            done_o  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (bit_load_i) begin
          shreg_d = {shreg_q[BYTE_W-2:0], 1'b0};
        end
      end
      default: state_d = RSP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RSP_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ack_req_o = (state_q == RSP_ACK);
  assign sda_low_o = (state_q == RSP_SHIFT) & ~shreg_q[BYTE_W-1];

  a_r7_ara_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RSP_IDLE && ara_hit_i && !alert_active_i) |=> !ack_req_o);
  a_r8_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RSP_SHIFT && !bit_load_i && !bit_sample_i) |=> $stable(sda_low_o));
  a_r10_lost_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RSP_SHIFT && bit_sample_i && lost) |=> (!sda_low_o && !ack_req_o));
  a_r6_ack_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_req_o, sda_low_o}));
endmodule

// File: rtl/smb_alert_unit.sv
module smb_alert_unit #(
  parameter int NFLT   = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLT-1:0]   fault_i,
  input  logic [NFLT-1:0]   alert_en_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              ara_hit_i,
  input  logic              dev_hit_i,
  input  logic              bit_load_i,
  input  logic              bit_sample_i,
  input  logic              sda_i,
  output logic              alert_n_o,
  output logic              ack_req_o,
  output logic              sda_low_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       rise_any, resp_done, alert_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  smb_alert_rearm #(.NFLT(NFLT)) u_rearm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .fault_i   (fault_i),
    .en_i      (alert_en_i),
    .rise_any_o(rise_any)
  );

  smb_alert_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rise_any_i (rise_any),
    .dev_hit_i  (dev_hit_i),
    .resp_done_i(resp_done),
    .alert_q_o  (alert_q)
  );

  smb_alert_responder #(.ADDR_W(ADDR_W)) u_resp (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .alert_active_i(alert_q),
    .ara_hit_i     (ara_hit_i),
    .bit_load_i    (bit_load_i),
    .bit_sample_i  (bit_sample_i),
    .sda_i         (sda_i),
    .dev_addr_i    (dev_addr_i),
    .ack_req_o     (ack_req_o),
    .sda_low_o     (sda_low_o),
    .done_o        (resp_done)
  );

  assign alert_n_o = ~alert_q;

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_core_n |-> (alert_n_o && !ack_req_o && !sda_low_o));
endmodule

// File: tb/test_smb_alert_unit.sv
module test_smb_alert_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NFLT = 8;
  localparam int ADDR_W = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic [NFLT-1:0] fault, en;
  logic [ADDR_W-1:0] addr;
  logic ara_hit, dev_hit, bit_load, bit_sample, mst_pull;
  logic alert_n, ack_req, sda_low, sda_bus;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = ~(sda_low | mst_pull);

  smb_alert_unit #(.NFLT(NFLT), .ADDR_W(ADDR_W)) i_smb_alert_unit (
    .clk(clk), .rst_n(rst_n), .fault_i(fault), .alert_en_i(en),
    .dev_addr_i(addr), .ara_hit_i(ara_hit), .dev_hit_i(dev_hit),
    .bit_load_i(bit_load), .bit_sample_i(bit_sample), .sda_i(sda_bus),
    .alert_n_o(alert_n), .ack_req_o(ack_req), .sda_low_o(sda_low)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Full alert-response byte; lose_at = byte bit index where master pulls low, -1 none
  task automatic respond(input logic [ADDR_W-1:0] a, input int lose_at);
    logic [7:0] byt;
    bit lost = 1'b0;
    addr = a;
    byt = {a, 1'b1};
    ara_hit = 1'b1; step(); ara_hit = 1'b0;
    check("R6 ack_req after response match", ack_req, 1);
    bit_load = 1'b1; step(); bit_load = 1'b0;
    check("R6 ack_req cleared at first load", ack_req, 0);
    for (int b = 7; b >= 0; b--) begin
      if (!lost) begin
        check("R8 response bit drive", sda_low, byt[b] ? 0 : 1);
        mst_pull = (b == lose_at);
        bit_sample = 1'b1; step(); bit_sample = 1'b0;
        mst_pull = 1'b0;
        if (b == lose_at) begin
          lost = 1'b1;
          check("R10 drive stops after loss", sda_low, 0);
          check("R10 alert kept after loss", alert_n, 0);
        end else if (b > 0) begin
          bit_load = 1'b1; step(); bit_load = 1'b0;
        end else begin
          check("R9 alert released after byte", alert_n, 1);
        end
      end else begin
        bit_load = 1'b1; step(); bit_load = 1'b0;
        check("R10 no drive for rest of byte", sda_low, 0);
        bit_sample = 1'b1; step(); bit_sample = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; fault = '0; en = '0; addr = '0;
    ara_hit = 0; dev_hit = 0; bit_load = 0; bit_sample = 0; mst_pull = 0;
    repeat (3) @(negedge clk);
    check("R1 alert_n in reset", alert_n, 1);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 alert_n after reset", alert_n, 1);
    check("R1 ack_req after reset", ack_req, 0);
    check("R1 sda_low after reset", sda_low, 0);

    // R2/R3 sweep over every bit with enable on and off
    for (int i = 0; i < NFLT; i++) begin
      for (int e = 0; e < 2; e++) begin
        fault = '0; en = e ? (NFLT'(1) << i) : ~(NFLT'(1) << i); step();
        fault = NFLT'(1) << i; step();
        check(e ? "R2 enabled fault asserts" : "R3 disabled fault quiet", alert_n, e ? 0 : 1);
        dev_hit = 1'b1; step(); dev_hit = 1'b0;
        check("R11 dev_hit releases", alert_n, 1);
        fault = '0; step();
      end
    end

    // R4/R5 re-arm rules
    en = '1; fault = 8'h08; step();
    check("R2 bit3 asserts", alert_n, 0);
    dev_hit = 1'b1; step(); dev_hit = 1'b0;
    repeat (3) step();
    check("R4 persisting fault no new alert", alert_n, 1);
    fault = 8'h28; step();
    check("R5 different bit re-alerts", alert_n, 0);
    dev_hit = 1'b1; step(); dev_hit = 1'b0;
    fault = 8'h20; step();
    check("R4 clearing bit no alert", alert_n, 1);
    fault = 8'h28; step();
    check("R4 bit re-set re-alerts", alert_n, 0);
    dev_hit = 1'b1; step(); dev_hit = 1'b0;

    // R12 release and new rise together
    fault = 8'h29; dev_hit = 1'b1; step(); dev_hit = 1'b0;
    check("R12 new rise beats release", alert_n, 0);
    dev_hit = 1'b1; step(); dev_hit = 1'b0;
    fault = '0; step();

    // R7 response match while not alerting
    ara_hit = 1'b1; step(); ara_hit = 1'b0;
    check("R7 no ack when idle", ack_req, 0);
    for (int k = 0; k < 3; k++) begin
      bit_load = 1'b1; step(); bit_load = 1'b0;
      check("R7 no drive when idle", sda_low, 0);
    end

    // R8/R9 response sweep over addresses
    for (int k = 0; k < 8; k++) begin
      fault = '0; step();
      fault = NFLT'(1) << k; step();
      check("R2 alert before response", alert_n, 0);
      respond(ADDR_W'((k * 37 + 5) & 127), -1);
    end
    fault = '0; step();

    // R10 arbitration loss at first released bit
    fault = 8'h01; step();
    respond(7'h5A, 7);
    check("R10 alert still low", alert_n, 0);
    dev_hit = 1'b1; step(); dev_hit = 1'b0;
    fault = '0; step();
    fault = 8'h02; step();
    respond(7'h1C, 5);
    dev_hit = 1'b1; step(); dev_hit = 1'b0;
    check("R11 release after loss", alert_n, 1);

    finished = 1'b1;
    summary();
  end
endmodule